// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Turnaround Trigger

This timer drives one shared up/down counter from a programmable prescaler. The counter climbs from 1 to a programmable top value and then falls back toward 1. A compare channel watches the shared count and drives a center-aligned PWM output that is high while the count is above a duty threshold. Each time that threshold is crossed, the channel raises a one-clock strobe, so the strobes fall on the two edges of the pulse.

A second channel has no output pin. It fires a one-clock strobe when the count arrives at the top value, which is where the counter reverses. Because the PWM is symmetric about that point, the strobe marks the middle of every high pulse. It is intended to start a sampling sequence that must stay aligned to the pulse center.

Software loads the prescaler, top value and duty threshold through a small write port. The writes go into holding registers. The running period always completes with its old settings, and the new values start at the next bottom of the count.

Top module: `cpwm_center_timer`

## Requirements
- R1: After reset the count is 1 and counting upward. The default duty threshold applies, so `pwm_out` is low, and `match_up`, `match_dn` and `center_trig` are low.
- R2: One counter step occurs every (prescale + 1) clocks. The count walks 1, 2, …, top, top−1, …, 2 and then back to 1 without repeating 1, so one period lasts (2·top − 2)·(prescale + 1) clocks.
- R3: `pwm_out` is high exactly while the count is greater than the active duty threshold.
- R4: `match_up` is a one-clock strobe in the first clock of the high pulse, when the count steps upward from the threshold. `match_dn` is a one-clock strobe in the first clock after the pulse, when the count steps downward onto the threshold.
- R5: `center_trig` is a one-clock strobe in the first clock in which the count equals top. It appears once per period and only when `trig_en` was high at that counter step.
- R6: New top, duty and prescale values are held back and take effect at the step that returns the count to 1. The period that is running when they are written keeps its old timing.
- R7: A duty threshold of 0 keeps `pwm_out` high for the whole period, and no edge strobe is produced.
- R8: A duty threshold at or above top keeps `pwm_out` low for the whole period, and no edge strobe is produced. The center strobe still fires.
- R9: The write select codes are: 0 sets the prescale value (divide by value + 1), 1 sets top, and 2 sets the duty threshold. Code 3 is ignored.
- R10: The smallest usable top value is 2, which gives a two-step period in which the center strobe and the rising strobe share a cycle. A top value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_sel | input | 2 | Register select: 0 prescale, 1 top, 2 duty, 3 none |
| wr_data | input | CNT_W | Write value |
| trig_en | input | 1 | Enables the center strobe |
| pwm_out | output | 1 | Center-aligned PWM output |
| match_up | output | 1 | Rising-edge compare strobe |
| match_dn | output | 1 | Falling-edge compare strobe |
| center_trig | output | 1 | Turnaround strobe at the middle of the high pulse |

## Verification
A wrong count, direction or prescale phase moves the three strobes away from their expected cycles. This shows up within one period, at the next threshold crossing or turnaround. Holding registers that load at the wrong moment move the edges inside the period in which the write was made, so that error shows before the next bottom. The bench compares the exact cycle of every strobe against a queue built from the period formula. A missing, extra or shifted strobe therefore shows up on the cycle where it should have appeared.

// File: rtl/cpwm_center_timer.sv
module cpwm_center_timer #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 16,
  parameter int DEF_PRE  = 0,
  parameter int DEF_TOP  = 8,
  parameter int DEF_DUTY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_en,
  output logic             pwm_out,
  output logic             match_up,
  output logic             match_dn,
  output logic             center_trig
);

  localparam logic [1:0]       SEL_PRE  = 2'd0;
  localparam logic [1:0]       SEL_TOP  = 2'd1;
  localparam logic [1:0]       SEL_DUTY = 2'd2;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO      = CNT_W'(2);
  localparam logic [CNT_W:0]   ONE_X    = (CNT_W+1)'(1);

  logic [PRE_W-1:0] pre_sh, pre_a, pre_cnt;
  logic [CNT_W-1:0] top_sh, duty_sh, top_a, duty_a, cnt, cnt_nx;
  logic             dir_up, tick, turn, bottom;

  assign tick    = pre_cnt == pre_a;
  assign turn    = !dir_up || cnt >= top_a;
  assign cnt_nx  = turn ? cnt - ONE : cnt + ONE;
  assign bottom  = cnt_nx == ONE;
  assign pwm_out = cnt > duty_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_sh  <= PRE_W'(DEF_PRE);
      top_sh  <= CNT_W'(DEF_TOP);
      duty_sh <= CNT_W'(DEF_DUTY);
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PRE:  pre_sh  <= wr_data[PRE_W-1:0];
        SEL_TOP:  top_sh  <= wr_data;
        SEL_DUTY: duty_sh <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt     <= '0;
      cnt         <= ONE;
      dir_up      <= 1'b1;
      pre_a       <= PRE_W'(DEF_PRE);
      top_a       <= CNT_W'(DEF_TOP);
      duty_a      <= CNT_W'(DEF_DUTY);
      match_up    <= 1'b0;
      match_dn    <= 1'b0;
      center_trig <= 1'b0;
    end else begin
      match_up    <= tick && !turn && cnt == duty_a;
      match_dn    <= tick && turn && ({1'b0, cnt} == {1'b0, duty_a} + ONE_X);
      center_trig <= tick && trig_en && !turn && (cnt + ONE == top_a);
      if (tick) begin
        pre_cnt <= '0;
        cnt     <= cnt_nx;
        dir_up  <= bottom || !turn;
        if (bottom) begin
          pre_a  <= pre_sh;
          top_a  <= (top_sh < TWO) ? TWO : top_sh;
          duty_a <= duty_sh;
        end
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt >= ONE && cnt <= top_a); // R2
  AST_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) match_up |-> pwm_out && !$past(pwm_out)); // R4
  AST_FALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) match_dn |-> $past(pwm_out)); // R4
  AST_CENTER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) center_trig |=> !center_trig); // R5
  AST_CENTER_GATED: assert property (@(posedge clk) disable iff (!rst_n) center_trig |-> $past(trig_en)); // R5
  AST_LOAD_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n) !$stable(duty_a) || !$stable(top_a) |-> cnt == ONE); // R6

endmodule

// File: tb/test_cpwm_center_timer.sv
module test_cpwm_center_timer;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n, wr_en, trig_en;
  logic [1:0] wr_sel;
  logic [CNT_W-1:0] wr_data;
  logic pwm_out, match_up, match_dn, center_trig;

  always #2ns clk = ~clk;

  cpwm_center_timer i_cpwm_center_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trig_en(trig_en), .pwm_out(pwm_out), .match_up(match_up), .match_dn(match_dn),
    .center_trig(center_trig)
  );

  typedef struct { int cyc; int kind; string req; } ev_t;
  ev_t q[$];
  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int c, input int k, input string r);
    ev_t e;
    e.cyc = c; e.kind = k; e.req = r;
    q.push_back(e);
  endtask

  // kind 0 rise, 1 center, 2 fall; centers at or after cut are not expected
  task automatic plan(input int b, input int p, input int t, input int d,
                      input int n_per, input string r, input int cut);
    for (int n = 0; n < n_per; n++) begin
      int base = b + n * (2*t - 2) * (p + 1);
      if (d >= 1 && d < t) push(base + d*(p+1), 0, r);
      if (base + (t-1)*(p+1) < cut) push(base + (t-1)*(p+1), 1, r);
      if (d >= 1 && d < t) push(base + (2*t - 1 - d)*(p+1), 2, r);
    end
  endtask

  task automatic take(input int k);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R5 unexpected strobe", k, -1);
    end else begin
      e = q.pop_front();
      chk(e.cyc == cyc && e.kind == k, e.req, cyc*4 + k, e.cyc*4 + e.kind);
      if (k == 0) chk(pwm_out == 1'b1, "R3 high at rise", pwm_out, 1);
      if (k == 2) chk(pwm_out == 1'b0, "R3 low at fall", pwm_out, 0);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        chk(1'b0, {q[0].req, " missing strobe"}, -1, q[0].cyc);
        void'(q.pop_front());
      end
      if (match_up) take(0);
      if (center_trig) take(1);
      if (match_dn) take(2);
    end
  end

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input int v);
    wr_en = 1'b1; wr_sel = s; wr_data = CNT_W'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lvl(input int from, input int to, input bit v, input string r);
    for (int c = from; c <= to; c++) begin
      wait_cyc(c);
      chk(pwm_out == v, r, pwm_out, v);
    end
  endtask

  initial begin
    #(4ns * 5000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; trig_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R1 pwm in reset", pwm_out, 0);
    chk({match_up, match_dn, center_trig} == 3'b000, "R1 strobes in reset",
        {match_up, match_dn, center_trig}, 0);
    plan(0,   0, 8, 4, 4,  "R2",    1000);
    plan(56,  1, 5, 2, 3,  "R6",    1000);
    plan(104, 1, 5, 0, 2,  "R7",    1000);
    plan(136, 1, 5, 7, 2,  "R8 R9", 1000);
    plan(168, 0, 2, 1, 12, "R10",   178);
    rst_n = 1'b1;
    mon_on = 1'b1;
    chk(pwm_out == 1'b0, "R1 pwm after release", pwm_out, 0);
    wait_cyc(44);
    wr(2'd0, 1); wr(2'd1, 5); wr(2'd2, 2);
    wait_cyc(92);
    wr(2'd2, 0);
    lvl(104, 129, 1'b1, "R7 held high");
    wr(2'd2, 7);
    wr(2'd3, 0);
    lvl(136, 159, 1'b0, "R8 held low");
    wr(2'd0, 0); wr(2'd1, 2); wr(2'd2, 1);
    wait_cyc(178);
    trig_en = 1'b0;
    wait_cyc(192);
    @(posedge clk);
    mon_on = 1'b0;
    chk(q.size() == 0, "R5 leftover expected strobes", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule